// File: doc/BRIEF.md
# Bit-Band Alias Memory Controller

This block connects a simple request/response bus to a single-port synchronous word RAM and places that storage behind two address windows. In the word window every aligned address reaches one full 32-bit word. In the bit alias window every 32-bit aligned alias word stands for a single bit of the RAM. Software can therefore test, set or clear one flag with a single access and does not need a read, mask and write sequence.

The alias address of bit `b` of the word at byte offset `o` in the word window is the alias base plus `o` shifted left by 5, plus `b` shifted left by 2. A read of an alias word returns the selected bit. A write of an alias word is carried out inside the block as a locked read-modify-write of the containing word. No other bus access can fall between its read and its write. Both windows reach the same cells, so a change made through either window is visible at once through the other. Any address outside both windows, including one that lies beyond the configured RAM depth, is answered with an error and does not touch the RAM.

Top module: `bitalias_mem_ctrl`

## Requirements
- R1: When reset is released, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The address `WORD_BASE + 4*i` with `i < RAM_WORDS` reaches word `i` as a full 32-bit value. A read returns the last value written to that word through either window.
- R3: A read of the address `ALIAS_BASE + ((4*i) << 5) + (b << 2)`, with `b` from 0 to 31, returns bit `b` of word `i` in `rsp_rdata[0]`. Bits 31:1 of `rsp_rdata` are 0.
- R4: A write to that alias address stores `req_wdata[0]` into bit `b` of word `i`. Bits 31:1 of `req_wdata` are ignored, and the other 31 bits of the word keep their values.
- R5: An accepted alias write holds `req_ready` low for the two cycles after acceptance. It reads the RAM word in the acceptance cycle, writes the merged word in the next cycle, and raises `rsp_valid` in the second cycle after acceptance.
- R6: A word written through the word window is seen by the next alias read, and a bit changed through the alias window is seen by the next word read.
- R7: An address outside both windows gets a response with `rsp_err` = 1 and `rsp_rdata` = 0. It causes no RAM write.
- R8: Every access other than an alias write is answered with `rsp_valid` in the first cycle after acceptance, and `req_ready` is low in that cycle. Write responses carry `rsp_rdata` = 0.
- R9: Each accepted request yields exactly one single-cycle `rsp_valid` pulse, and `rsp_err` is never 1 without `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; accepted on a rising edge where `req_ready` is 1 |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_we | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | DW | Write data; only bit 0 is used for an alias write |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | DW | Read data; 0 for writes and errors |
| rsp_err | output | 1 | Address decoded to neither window |

## Verification
The hardest case to reach from the ports is an alias write whose merged word has to keep 31 unrelated bits intact while the addressed bit sits at the edge of the range, for example bit 31 of the last RAM word, directly followed by a read of the same word through the other window. The stimulus first fills every word with a known pattern so that each bit has a reference value. It then mixes directed accesses at the window edges with a long seeded random stream over a small RAM, so that alias writes, alias reads and word reads often land on the same word back to back. Write data with noise in bits 31:1 and addresses just outside each window are also included.

// File: rtl/bitalias_pkg.sv
// Shared types for the bit-band alias memory controller.
// Assumes: the word and alias windows do not overlap.
package bitalias_pkg;

    // Window an address decodes to
    typedef enum logic [1:0] {
        ACC_WORD = 2'd0,
        ACC_BIT  = 2'd1,
        ACC_BAD  = 2'd2
    } acc_win_e;

    // Sequencer state
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MODIFY = 2'd1,
        ST_RESP   = 2'd2
    } seq_state_e;

    // Kind of response owed to the requester
    typedef enum logic [1:0] {
        RK_WORD_RD = 2'd0,
        RK_BIT_RD  = 2'd1,
        RK_WRITE   = 2'd2,
        RK_ERR     = 2'd3
    } rsp_kind_e;

endpackage

// File: rtl/bitalias_addr_decode.sv
// Address decoder: maps a byte address to a window, a word index and a bit position.
// Assumes: both bases are aligned, the alias window spans 32x the word window bytes,
// and the two windows do not overlap. The low byte-lane bits are ignored.
module bitalias_addr_decode
    import bitalias_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              DW         = 32,
    parameter int              RAM_WORDS  = 64,
    parameter logic [ADDR_W-1:0] WORD_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic [ADDR_W-1:0]            addr,
    output acc_win_e                     win,
    output logic [$clog2(RAM_WORDS)-1:0] word_idx,
    output logic [$clog2(DW)-1:0]        bit_pos
);
    localparam int IDX_W   = $clog2(RAM_WORDS);
    localparam int BIT_W   = $clog2(DW);
    localparam int BYTE_SH = $clog2(DW / 8);
    localparam logic [ADDR_W-1:0] WIN_BYTES   = ADDR_W'(RAM_WORDS * (DW / 8));
    localparam logic [ADDR_W-1:0] ALIAS_BYTES = ADDR_W'(RAM_WORDS * (DW / 8) * DW);

    logic [ADDR_W-1:0] word_off;
    logic [ADDR_W-1:0] alias_off;

    // Offsets from each window base
    always_comb begin
        word_off  = addr - WORD_BASE;
        alias_off = addr - ALIAS_BASE;
    end

    // Range compare and field extraction
    always_comb begin
        win      = ACC_BAD;
        word_idx = '0;
        bit_pos  = '0;
        if ((addr >= WORD_BASE) && (word_off < WIN_BYTES)) begin
            win      = ACC_WORD;
            word_idx = IDX_W'(word_off >> BYTE_SH);
        end else if ((addr >= ALIAS_BASE) && (alias_off < ALIAS_BYTES)) begin
            win      = ACC_BIT;
            word_idx = IDX_W'(alias_off >> (BYTE_SH + BIT_W));
            bit_pos  = BIT_W'(alias_off >> BYTE_SH);
        end
    end

endmodule

// File: rtl/bitalias_sp_ram.sv
// Single-port synchronous word RAM with one cycle of read latency.
// Assumes: a write leaves the read register unchanged; contents are not reset.
module bitalias_sp_ram #(
    parameter int DW    = 32,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     en,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write the array or register a read word
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/bitalias_bit_merge.sv
// Replaces one bit of a word with a new value and passes all other bits through.
// Assumes: bit_sel is below DW.
module bitalias_bit_merge #(
    parameter int DW    = 32,
    parameter int BIT_W = 5
) (
    input  logic [DW-1:0]    old_word,
    input  logic [BIT_W-1:0] bit_sel,
    input  logic             bit_val,
    output logic [DW-1:0]    new_word
);
    // One lane per bit: pick the new value at the selected position
    for (genvar gi = 0; gi < DW; gi++) begin : g_lane
        assign new_word[gi] = (bit_sel == BIT_W'(gi)) ? bit_val : old_word[gi];
    end

endmodule

// File: rtl/bitalias_seq.sv
// Access sequencer: takes one request at a time, drives the RAM port, performs
// the locked read-modify-write for alias writes and forms the response.
// Assumes: the decoder output belongs to the request currently on the bus, and
// the RAM returns read data one cycle after the read.
module bitalias_seq
    import bitalias_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 6,
    parameter int BIT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic [DW-1:0]    req_wdata,
    input  acc_win_e         dec_win,
    input  logic [IDX_W-1:0] dec_idx,
    input  logic [BIT_W-1:0] dec_bit,
    output logic             req_ready,
    output logic             ram_en,
    output logic             ram_we,
    output logic [IDX_W-1:0] ram_addr,
    output logic [DW-1:0]    ram_wdata,
    input  logic [DW-1:0]    ram_rdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_err
);
    seq_state_e       state_q, state_d;
    rsp_kind_e        kind_q, kind_d;
    logic [IDX_W-1:0] idx_q;
    logic [BIT_W-1:0] bit_q;
    logic             val_q;
    logic             accept;
    logic [DW-1:0]    merged;

    assign accept = req_valid && (state_q == ST_IDLE);

    bitalias_bit_merge #(
        .DW    (DW),
        .BIT_W (BIT_W)
    ) u_merge (
        .old_word (ram_rdata),
        .bit_sel  (bit_q),
        .bit_val  (val_q),
        .new_word (merged)
    );

    // Next state and the kind of response owed
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_RESP;
                    case (dec_win)
                        ACC_WORD: kind_d = req_we ? RK_WRITE : RK_WORD_RD;
                        ACC_BIT: begin
                            kind_d = req_we ? RK_WRITE : RK_BIT_RD;
                            if (req_we) begin
                                state_d = ST_MODIFY;
                            end
                        end
                        default: kind_d = RK_ERR;
                    endcase
                end
            end
            ST_MODIFY: state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and captured request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= RK_WRITE;
            idx_q   <= '0;
            bit_q   <= '0;
            val_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            if (accept) begin
                idx_q <= dec_idx;
                bit_q <= dec_bit;
                val_q <= req_wdata[0];
            end
        end
    end

    // RAM port: direct access on acceptance, merged write-back in the modify cycle
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = dec_idx;
        ram_wdata = req_wdata;
        if (accept && (dec_win != ACC_BAD)) begin
            ram_en = 1'b1;
            ram_we = req_we && (dec_win == ACC_WORD);
        end else if (state_q == ST_MODIFY) begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = idx_q;
            ram_wdata = merged;
        end
    end

    // Response data shaped by the kind of access
    always_comb begin
        rsp_rdata = '0;
        if (state_q == ST_RESP) begin
            case (kind_q)
                RK_WORD_RD: rsp_rdata = ram_rdata;
                RK_BIT_RD:  rsp_rdata = DW'(ram_rdata[bit_q]);
                default:    rsp_rdata = '0;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_err   = (state_q == ST_RESP) && (kind_q == RK_ERR);

endmodule

// File: rtl/bitalias_mem_ctrl.sv
// Bit-band alias memory controller top: word window and bit alias window over
// one single-port RAM.
// Assumes: one requester; one request in flight at a time; the windows do not overlap.
module bitalias_mem_ctrl
    import bitalias_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              DW         = 32,
    parameter int              RAM_WORDS  = 64,
    parameter logic [ADDR_W-1:0] WORD_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              rsp_err
);
    localparam int IDX_W = $clog2(RAM_WORDS);
    localparam int BIT_W = $clog2(DW);

    acc_win_e         dec_win;
    logic [IDX_W-1:0] dec_idx;
    logic [BIT_W-1:0] dec_bit;
    logic             ram_en;
    logic             ram_we;
    logic [IDX_W-1:0] ram_addr;
    logic [DW-1:0]    ram_wdata;
    logic [DW-1:0]    ram_rdata;

    bitalias_addr_decode #(
        .ADDR_W     (ADDR_W),
        .DW         (DW),
        .RAM_WORDS  (RAM_WORDS),
        .WORD_BASE  (WORD_BASE),
        .ALIAS_BASE (ALIAS_BASE)
    ) u_decode (
        .addr     (req_addr),
        .win      (dec_win),
        .word_idx (dec_idx),
        .bit_pos  (dec_bit)
    );

    bitalias_seq #(
        .DW    (DW),
        .IDX_W (IDX_W),
        .BIT_W (BIT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .dec_win   (dec_win),
        .dec_idx   (dec_idx),
        .dec_bit   (dec_bit),
        .req_ready (req_ready),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    bitalias_sp_ram #(
        .DW    (DW),
        .DEPTH (RAM_WORDS)
    ) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

endmodule

// File: rtl/bitalias_mem_ctrl_chk.sv
// Protocol and timing checker for the bit-band alias memory controller.
// Assumes: attached by bind; windows worked out here from the parameters alone.
module bitalias_mem_ctrl_chk #(
    parameter int              ADDR_W     = 32,
    parameter int              DW         = 32,
    parameter int              RAM_WORDS  = 64,
    parameter logic [ADDR_W-1:0] WORD_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_we,
    input logic              rsp_valid,
    input logic [DW-1:0]     rsp_rdata,
    input logic              rsp_err,
    input logic              ram_we,
    input logic [DW-1:0]     ram_wdata,
    input logic [DW-1:0]     ram_rdata
);
    localparam logic [ADDR_W-1:0] WORD_END  = WORD_BASE + ADDR_W'(RAM_WORDS * (DW / 8));
    localparam logic [ADDR_W-1:0] ALIAS_END = ALIAS_BASE + ADDR_W'(RAM_WORDS * (DW / 8) * DW);

    logic took;
    logic in_word;
    logic in_alias;

    assign took     = req_valid && req_ready;
    assign in_word  = (req_addr >= WORD_BASE) && (req_addr < WORD_END);
    assign in_alias = (req_addr >= ALIAS_BASE) && (req_addr < ALIAS_END);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (req_ready && !rsp_valid));

    // R9
    err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> !req_ready);

    // R8
    short_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && !(in_alias && req_we)) |=> rsp_valid);

    // R5
    rmw_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && in_alias && req_we) |=> (!rsp_valid && !req_ready) ##1 rsp_valid);

    // R4
    rmw_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && in_alias && req_we) |=> (ram_we && ($countones(ram_wdata ^ ram_rdata) <= 1)));

    // R7
    bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && !in_alias && !in_word) |-> !ram_we);

    // R7
    bad_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && !in_alias && !in_word) |=> (rsp_valid && rsp_err));

    // R3
    bit_read_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && in_alias && !req_we) |=> ((rsp_rdata >> 1) == '0));

endmodule

bind bitalias_mem_ctrl bitalias_mem_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DW         (DW),
    .RAM_WORDS  (RAM_WORDS),
    .WORD_BASE  (WORD_BASE),
    .ALIAS_BASE (ALIAS_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_we    (req_we),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata)
);

// File: tb/bitalias_mem_ctrl_bench.sv
// Self-checking bench: seeded random traffic plus directed edge cases against a
// reference word array kept by the bench.
module bitalias_mem_ctrl_bench;
    localparam int          RAM_WORDS   = 64;
    localparam logic [31:0] WORD_BASE   = 32'h2000_0000;
    localparam logic [31:0] ALIAS_BASE  = 32'h2200_0000;
    localparam logic [31:0] WIN_BYTES   = RAM_WORDS * 4;
    localparam logic [31:0] ALIAS_BYTES = RAM_WORDS * 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] ref_mem [RAM_WORDS];

    always #2.5 clk = ~clk;

    bitalias_mem_ctrl u_bitalias_mem_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // 0 = word window, 1 = alias window, 2 = neither
    function automatic int win_of(input logic [31:0] a);
        if (a >= WORD_BASE && (a - WORD_BASE) < WIN_BYTES) return 0;
        if (a >= ALIAS_BASE && (a - ALIAS_BASE) < ALIAS_BYTES) return 1;
        return 2;
    endfunction

    function automatic logic [31:0] word_addr(input int idx);
        return WORD_BASE + 32'(idx * 4);
    endfunction

    function automatic logic [31:0] alias_addr(input int idx, input int b);
        return ALIAS_BASE + (32'(idx * 4) << 5) + (32'(b) << 2);
    endfunction

    // One transaction with reference update and all response checks
    task automatic run_op(input logic [31:0] a, input bit we, input logic [31:0] wd, input string tag);
        int          w;
        int          idx;
        int          b;
        int          exp_lat;
        logic [31:0] exp_rd;
        bit          exp_err;
        int          lat;
        logic [31:0] off;
        w = win_of(a);
        exp_rd = '0; exp_err = 1'b0; exp_lat = 1;
        if (w == 0) begin
            idx = int'((a - WORD_BASE) >> 2);
            if (we) ref_mem[idx] = wd;
            else    exp_rd = ref_mem[idx];
        end else if (w == 1) begin
            off = a - ALIAS_BASE;
            idx = int'(off >> 7);
            b   = int'((off >> 2) & 32'd31);
            if (we) begin
                ref_mem[idx][b] = wd[0];
                exp_lat = 2;
            end else begin
                exp_rd = {31'b0, ref_mem[idx][b]};
            end
        end else begin
            exp_err = 1'b1;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0; req_wdata = '0;
        chk(req_ready == 1'b0, {tag, " R8 ready low after accept"}, 32'(req_ready), 32'd0);
        lat = 1;
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, {tag, (exp_lat == 2) ? " R5 latency" : " R8 latency"}, 32'(lat), 32'(exp_lat));
        chk(rsp_rdata === exp_rd, {tag, " data"}, rsp_rdata, exp_rd);
        chk(rsp_err === exp_err, {tag, " R7 err flag"}, 32'(rsp_err), 32'(exp_err));
        @(negedge clk);
        chk(rsp_valid == 1'b0, {tag, " R9 single pulse"}, 32'(rsp_valid), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);

        // R2 fill every word with a known pattern
        for (int i = 0; i < RAM_WORDS; i++) begin
            run_op(word_addr(i), 1'b1, (32'(i) * 32'h0101_0101) ^ 32'hC33C_5AA5, "R2 fill");
        end
        for (int i = 0; i < RAM_WORDS; i += 7) begin
            run_op(word_addr(i), 1'b0, '0, "R2 word read");
        end

        // R3 alias reads at both ends of the alias window
        run_op(alias_addr(0, 0), 1'b0, '0, "R3 first alias bit");
        run_op(alias_addr(RAM_WORDS - 1, 31), 1'b0, '0, "R3 last alias bit");

        // R4 clear with noise in bits 31:1, then set bit 31 of the last word
        run_op(alias_addr(3, 5), 1'b1, 32'hFFFF_FFFE, "R4 clear ignores upper");
        run_op(word_addr(3), 1'b0, '0, "R6 word sees alias clear");
        run_op(alias_addr(RAM_WORDS - 1, 31), 1'b1, 32'h0000_0001, "R4 set top bit");
        run_op(word_addr(RAM_WORDS - 1), 1'b0, '0, "R6 word sees alias set");
        run_op(alias_addr(9, 0), 1'b1, 32'hFFFF_FFFF, "R4 set bit0");
        run_op(alias_addr(9, 0), 1'b0, '0, "R3 alias sees alias set");

        // R6 word write seen through the alias window
        run_op(word_addr(12), 1'b1, 32'h8000_0001, "R6 word write");
        run_op(alias_addr(12, 31), 1'b0, '0, "R6 alias sees word bit31");
        run_op(alias_addr(12, 30), 1'b0, '0, "R6 alias sees word bit30");

        // R7 addresses just outside each window, then verify nothing moved
        run_op(WORD_BASE + WIN_BYTES, 1'b1, 32'hDEAD_BEEF, "R7 past word window");
        run_op(ALIAS_BASE + ALIAS_BYTES, 1'b1, 32'h1, "R7 past alias window");
        run_op(WORD_BASE - 32'd4, 1'b0, '0, "R7 below word window");
        run_op(32'h0000_0000, 1'b1, 32'hFFFF_FFFF, "R7 address zero");
        run_op(word_addr(RAM_WORDS - 1), 1'b0, '0, "R7 last word unchanged");
        run_op(word_addr(0), 1'b0, '0, "R7 first word unchanged");

        // Seeded random mix over all access kinds
        for (int k = 0; k < 400; k++) begin
            int          sel;
            int          idx;
            int          b;
            logic [31:0] a;
            sel = int'($urandom % 10);
            idx = int'($urandom % RAM_WORDS);
            b   = int'($urandom % 32);
            if (sel < 3) begin
                run_op(word_addr(idx), ($urandom % 2) == 0, $urandom, "R2 random word");
            end else if (sel < 6) begin
                run_op(alias_addr(idx, b), 1'b0, '0, "R3 random alias read");
            end else if (sel < 9) begin
                run_op(alias_addr(idx, b), 1'b1, $urandom, "R4 random alias write");
            end else begin
                case ($urandom % 4)
                    0: a = WORD_BASE + WIN_BYTES + 32'(4 * ($urandom % 64));
                    1: a = ALIAS_BASE + ALIAS_BYTES + 32'(4 * ($urandom % 256));
                    2: a = WORD_BASE - 32'd4 - 32'(4 * ($urandom % 16));
                    default: a = $urandom & 32'h1FFF_FFFC;
                endcase
                run_op(a, ($urandom % 2) == 0, $urandom, "R7 random bad address");
            end
        end

        // R6 final sweep: every word read back against the reference
        for (int i = 0; i < RAM_WORDS; i++) begin
            run_op(word_addr(i), 1'b0, '0, "R6 final sweep");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule